// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block makes one clamp pulse per horizontal line for a display front end. The pulse is timed from the horizontal drive. A position mode puts the pulse either inside the sync interval or in the back porch. In the automatic mode, the presence of composite sync chooses between the two. The start delay and the width of the pulse are set in clock cycles by configuration inputs. An analog current setting is not used.

During the vertical drive interval, the pulse is held off when the sync comes from a composite or video source. When separate horizontal and vertical sync are in use, the pulse keeps running through the vertical interval. The block drives two outputs of opposite polarity.

Top module: `clamp_pulse_gen`

## Requirements
- R1: After reset, and until the first trigger, `clampPos` is 0 and `clampNeg` is 1.
- R2: With `posMode` = 2'b00 (back porch), a trigger happens at the clock edge where `hDrive` is sampled 0 and its previous sample was 1. If the trigger happens at edge E, `clampPos` is high after edges E+D through E+D+W-1. D is `delayCfg` and W is `widthCfg`, so with D = 0 the pulse is high right after edge E.
- R3: With `posMode` = 2'b01 (sync interval), the trigger is the edge where `hDrive` is sampled 1 and its previous sample was 0. The timing is the same as in R2.
- R4: With `posMode` = 2'b10 (automatic), the block triggers on the rising edge when `compPresent` is 1 and on the falling edge when `compPresent` is 0.
- R5: `posMode` = 2'b11 behaves exactly like 2'b00.
- R6: When `sepSync` is 0, `clampPos` is low after any edge at which `vDrive` is sampled 1. The pulse timing keeps running underneath and is not restarted.
- R7: When `sepSync` is 1, `vDrive` has no effect on the outputs.
- R8: A trigger that arrives while a delay or a pulse is in progress restarts the timing from that edge.
- R9: `widthCfg` = 0 produces no pulse.
- R10: `delayCfg` and `widthCfg` are captured at the trigger edge. Changing them later has no effect until the next trigger.
- R11: `clampNeg` is always the inverse of `clampPos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hDrive | input | 1 | Horizontal drive, active high |
| vDrive | input | 1 | Vertical drive, active high |
| posMode | input | 2 | 00 back porch, 01 sync interval, 10 automatic, 11 as 00 |
| compPresent | input | 1 | Composite sync detected |
| sepSync | input | 1 | Separate H/V sync source in use |
| delayCfg | input | DELAY_BITS | Cycles from trigger to pulse start |
| widthCfg | input | WIDTH_BITS | Pulse width in cycles |
| clampPos | output | 1 | Clamp pulse, active high |
| clampNeg | output | 1 | Clamp pulse, active low |

## Verification
The hardest case to reach is a trigger that lands while an earlier pulse is still in its delay or width phase, combined with configuration values that change mid-pulse. The bench reaches this by shortening the line period below the delay plus the width, and by rewriting `widthCfg` a few cycles after a back-porch edge. A behavioural model keeps only the cycle of the latest trigger and the captured values. The bench checks every cycle against that model, including while the vertical drive blanks the output.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_PULSE = 2'd2
  } clampState_t;

  typedef struct packed {
    logic capture;      // latch configuration
    logic loadDelay;    // counter <= delay input
    logic loadWidthIn;  // counter <= width input (zero delay)
    logic loadWidthHold;// counter <= captured width
    logic dec;          // counter decrement
  } clampStrobe_t;

  function automatic logic syncPosition(input logic [1:0] mode, input logic comp);
    return (mode == 2'b01) || ((mode == 2'b10) && comp);
  endfunction
endpackage

// File: rtl/clamp_datapath.sv
module clamp_datapath
  import clamp_pkg::*;
#(
  parameter int DELAY_BITS = 4,
  parameter int WIDTH_BITS = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hDrive,
  input  logic                  vDrive,
  input  logic                  sepSync,
  input  logic [DELAY_BITS-1:0] delayCfg,
  input  logic [WIDTH_BITS-1:0] widthCfg,
  input  clampStrobe_t          strobe,
  output logic                  hRise,
  output logic                  hFall,
  output logic                  cntOne,
  output logic                  cfgDelayZero,
  output logic                  cfgWidthZero,
  output logic                  holdWidthZero,
  output logic                  vBlank
);
  localparam int CNT_BITS = (DELAY_BITS > WIDTH_BITS) ? DELAY_BITS : WIDTH_BITS;

  logic                  hPrev;
  logic [WIDTH_BITS-1:0] widthHold;
  logic [CNT_BITS-1:0]   cnt;

  assign hRise         = hDrive & ~hPrev;
  assign hFall         = ~hDrive & hPrev;
  assign cfgDelayZero  = (delayCfg == '0);
  assign cfgWidthZero  = (widthCfg == '0);
  assign holdWidthZero = (widthHold == '0);
  assign cntOne        = (cnt == CNT_BITS'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPrev  <= 1'b0;
      vBlank <= 1'b0;
    end else begin
      hPrev  <= hDrive;
      vBlank <= vDrive & ~sepSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) widthHold <= '0;
    else if (strobe.capture) widthHold <= widthCfg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     cnt <= '0;
    else if (strobe.loadDelay)     cnt <= CNT_BITS'(delayCfg);
    else if (strobe.loadWidthIn)   cnt <= CNT_BITS'(widthCfg);
    else if (strobe.loadWidthHold) cnt <= CNT_BITS'(widthHold);
    else if (strobe.dec)           cnt <= cnt - CNT_BITS'(1);
  end

  // R8: a decrement moves the counter down by exactly one
  p_count_down_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.loadDelay && !strobe.loadWidthIn && !strobe.loadWidthHold)
      |=> cnt == $past(cnt) - CNT_BITS'(1));

  // R10: the captured width matches the input at the capture edge
  p_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> widthHold == $past(widthCfg));
endmodule

// File: rtl/clamp_control.sv
module clamp_control
  import clamp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   posMode,
  input  logic         compPresent,
  input  logic         hRise,
  input  logic         hFall,
  input  logic         cntOne,
  input  logic         cfgDelayZero,
  input  logic         cfgWidthZero,
  input  logic         holdWidthZero,
  output clampStrobe_t strobe,
  output logic         pulseActive
);
  clampState_t stateR, stateNext;
  logic        trig;

  assign trig        = syncPosition(posMode, compPresent) ? hRise : hFall;
  assign pulseActive = (stateR == ST_PULSE);

  always_comb begin
    stateNext = stateR;
    strobe    = '0;
    if (trig) begin
      strobe.capture = 1'b1;
      if (!cfgDelayZero) begin
        stateNext        = ST_WAIT;
        strobe.loadDelay = 1'b1;
      end else if (!cfgWidthZero) begin
        stateNext          = ST_PULSE;
        strobe.loadWidthIn = 1'b1;
      end else begin
        stateNext = ST_IDLE;
      end
    end else begin
      unique case (stateR)
        ST_WAIT: begin
          if (cntOne) begin
            if (holdWidthZero) stateNext = ST_IDLE;
            else begin
              stateNext            = ST_PULSE;
              strobe.loadWidthHold = 1'b1;
            end
          end else strobe.dec = 1'b1;
        end
        ST_PULSE: begin
          if (cntOne) stateNext = ST_IDLE;
          else strobe.dec = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateR <= ST_IDLE;
    else       stateR <= stateNext;
  end

  // R8: a trigger with nonzero width always starts a new timing run
  p_trigger_starts_r8: assert property (@(posedge clk) disable iff (!rstN)
    (trig && !cfgWidthZero) |=> stateR != ST_IDLE);

  // R2: zero delay puts the pulse right after the trigger edge
  p_zero_delay_r2: assert property (@(posedge clk) disable iff (!rstN)
    (trig && cfgDelayZero && !cfgWidthZero) |=> pulseActive);

  // R9: zero width with zero delay gives no pulse
  p_zero_width_r9: assert property (@(posedge clk) disable iff (!rstN)
    (trig && cfgDelayZero && cfgWidthZero) |=> !pulseActive);
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
  import clamp_pkg::*;
#(
  parameter int DELAY_BITS = 4,
  parameter int WIDTH_BITS = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hDrive,
  input  logic                  vDrive,
  input  logic [1:0]            posMode,
  input  logic                  compPresent,
  input  logic                  sepSync,
  input  logic [DELAY_BITS-1:0] delayCfg,
  input  logic [WIDTH_BITS-1:0] widthCfg,
  output logic                  clampPos,
  output logic                  clampNeg
);
  clampStrobe_t strobe;
  logic hRise, hFall, cntOne, cfgDelayZero, cfgWidthZero, holdWidthZero;
  logic vBlank, pulseActive;

  clamp_datapath #(.DELAY_BITS(DELAY_BITS), .WIDTH_BITS(WIDTH_BITS)) i_datapath (
    .clk(clk), .rstN(rstN), .hDrive(hDrive), .vDrive(vDrive), .sepSync(sepSync),
    .delayCfg(delayCfg), .widthCfg(widthCfg), .strobe(strobe),
    .hRise(hRise), .hFall(hFall), .cntOne(cntOne), .cfgDelayZero(cfgDelayZero),
    .cfgWidthZero(cfgWidthZero), .holdWidthZero(holdWidthZero), .vBlank(vBlank)
  );

  clamp_control i_control (
    .clk(clk), .rstN(rstN), .posMode(posMode), .compPresent(compPresent),
    .hRise(hRise), .hFall(hFall), .cntOne(cntOne), .cfgDelayZero(cfgDelayZero),
    .cfgWidthZero(cfgWidthZero), .holdWidthZero(holdWidthZero),
    .strobe(strobe), .pulseActive(pulseActive)
  );

  assign clampPos = pulseActive & ~vBlank;
  assign clampNeg = ~clampPos;

  // R6: vertical drive on a composite/video source blanks the next cycle
  p_vblank_r6: assert property (@(posedge clk) disable iff (!rstN)
    (vDrive && !sepSync) |=> !clampPos);
endmodule

// File: tb/test_clamp_pulse_gen.sv
module test_clamp_pulse_gen;
  localparam int DB = 4;
  localparam int WB = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic hDrive = 1'b0, vDrive = 1'b0, compPresent = 1'b0, sepSync = 1'b0;
  logic [1:0] posMode = 2'b00;
  logic [DB-1:0] delayCfg = '0;
  logic [WB-1:0] widthCfg = '0;
  logic clampPos, clampNeg;

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";

  // reference model state
  int  edgeN = 0, trigEdge = -1, dHold = 0, wHold = 0;
  bit  hPrevM = 0, blankM = 0, expPos = 0;

  clamp_pulse_gen #(.DELAY_BITS(DB), .WIDTH_BITS(WB)) i_clamp_pulse_gen (
    .clk(clk), .rstN(rstN), .hDrive(hDrive), .vDrive(vDrive), .posMode(posMode),
    .compPresent(compPresent), .sepSync(sepSync), .delayCfg(delayCfg),
    .widthCfg(widthCfg), .clampPos(clampPos), .clampNeg(clampNeg)
  );

  always #5 clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeN = 0; trigEdge = -1; hPrevM = 0; blankM = 0; expPos = 0;
    end else begin
      bit useRise, rise, fall, act;
      edgeN++;
      useRise = (posMode == 2'b01) || (posMode == 2'b10 && compPresent);
      rise = hDrive && !hPrevM;
      fall = !hDrive && hPrevM;
      if (useRise ? rise : fall) begin
        trigEdge = edgeN; dHold = int'(delayCfg); wHold = int'(widthCfg);
      end
      hPrevM = hDrive;
      blankM = vDrive && !sepSync;
      act = (trigEdge >= 0) && (edgeN - trigEdge >= dHold) && (edgeN - trigEdge < dHold + wHold);
      expPos = act && !blankM;
    end
  end

  task automatic checkNow();
    checks++;
    if (clampPos !== expPos) begin
      errors++;
      $display("FAIL %s clampPos actual=%b expected=%b cycle=%0d", tag, clampPos, expPos, cycles);
    end
    checks++;
    if (clampNeg !== !expPos) begin
      errors++;
      $display("FAIL R11 clampNeg actual=%b expected=%b cycle=%0d", clampNeg, !expPos, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) checkNow();
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic lines(input int n, input int hi, input int lo);
    for (int k = 0; k < n; k++) begin
      hDrive = 1'b1;
      repeat (hi) @(negedge clk);
      hDrive = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state checked directly
    checks++;
    if (clampPos !== 1'b0 || clampNeg !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset actual=%b%b expected=01", clampPos, clampNeg);
    end
    rstN = 1'b1;
    tag = "R1"; repeat (4) @(negedge clk);

    tag = "R2"; posMode = 2'b00; delayCfg = 4'd2; widthCfg = 6'd4; lines(3, 3, 14);
    tag = "R2"; delayCfg = 4'd0; widthCfg = 6'd1; lines(2, 3, 10);
    tag = "R3"; posMode = 2'b01; delayCfg = 4'd1; widthCfg = 6'd3; lines(3, 4, 12);
    tag = "R4"; posMode = 2'b10; compPresent = 1'b1; delayCfg = 4'd0; widthCfg = 6'd5; lines(2, 3, 12);
    tag = "R4"; compPresent = 1'b0; lines(2, 3, 12);
    tag = "R5"; posMode = 2'b11; compPresent = 1'b1; delayCfg = 4'd3; widthCfg = 6'd2; lines(2, 5, 12);
    tag = "R9"; posMode = 2'b01; delayCfg = 4'd2; widthCfg = 6'd0; lines(2, 3, 10);
    tag = "R9"; delayCfg = 4'd0; lines(2, 3, 10);
    tag = "R8"; delayCfg = 4'd2; widthCfg = 6'd12; lines(5, 2, 4);
    lines(1, 2, 20);
    tag = "R6"; posMode = 2'b00; delayCfg = 4'd0; widthCfg = 6'd8; sepSync = 1'b0;
    hDrive = 1'b1; repeat (2) @(negedge clk); hDrive = 1'b0;
    repeat (3) @(negedge clk); vDrive = 1'b1; repeat (2) @(negedge clk); vDrive = 1'b0;
    repeat (10) @(negedge clk);
    vDrive = 1'b1; lines(3, 3, 10); vDrive = 1'b0;
    tag = "R7"; sepSync = 1'b1; vDrive = 1'b1; lines(3, 3, 12); vDrive = 1'b0;
    tag = "R10"; posMode = 2'b00; delayCfg = 4'd1; widthCfg = 6'd8;
    hDrive = 1'b1; repeat (2) @(negedge clk); hDrive = 1'b0;
    repeat (3) @(negedge clk); widthCfg = 6'd2; delayCfg = 4'd5;
    repeat (12) @(negedge clk);
    widthCfg = 6'd3; delayCfg = 4'd1; lines(1, 2, 10);
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule